// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models the command logic of a byte-wide parallel NOR flash as synthesizable RTL. A host issues bus write cycles (address plus data, one clock pulse each on `wr_en`) and bus read cycles (`rd_en` with an address). Multi-cycle unlock sequences are recognised for byte program, sector erase, chip erase, and entering or leaving a product identification mode. Each write has to present exact address and data values. A recognised program or erase updates a small on-chip byte array and then holds the block busy for a parameterised number of clock cycles.

While busy, reads return a status byte instead of array contents. Bit 7 holds the complement of the value the operation is writing to bit 7. Bit 6 inverts on every status read. Host software finds completion in one of two ways: it waits for bit 7 to read true, or it waits for two consecutive reads to return the same value. In identification mode, reads return a fixed manufacturer code and a fixed device code instead of array data.

The decoder FSM has these states. `SEQ_IDLE` waits for a command. `SEQ_UNL1` means the first unlock byte has been seen. `SEQ_UNL2` means the second unlock byte has been seen. `SEQ_PGM_DATA` waits for the program address and data. `SEQ_ERS3`, `SEQ_ERS4` and `SEQ_ERS5` track the erase prefix. The transitions are:
- IDLE→UNL1 on AAH@5555H.
- UNL1→UNL2 on 55H@2AAAH.
- UNL2→PGM_DATA on A0H@5555H.
- UNL2→ERS3 on 80H@5555H.
- UNL2→IDLE on 90H@5555H, which enters ID mode.
- ERS3→ERS4 on AAH@5555H.
- ERS4→ERS5 on 55H@2AAAH.
- ERS5→IDLE on 10H@5555H (chip erase) or on 30H at a sector address (sector erase).
- PGM_DATA→IDLE on any write, which starts the program.
- Any other write returns the FSM to IDLE.

Top module: `flash_cmd_core`

## Requirements
- R1: After reset, every array byte reads FFH, ID mode is off, the decoder is in SEQ_IDLE and `rd_data` is 00H.
- R2: The three writes AAH@5555H, 55H@2AAAH, A0H@5555H, followed by a fourth write at any address, program the fourth write's data at array index `addr[IDX_W-1:0]`. Unlock addresses are compared on `addr[14:0]`.
- R3: Programming only clears bits: the new byte is the old byte AND the written data.
- R4: The writes AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, 10H@5555H set every array byte to FFH.
- R5: The same five-write prefix followed by data 30H at any address sets to FFH every byte whose index bits `[IDX_W-1:SOFF_W]` equal those of that address. No other byte changes.
- R6: A write whose address or data does not match the expected step returns the decoder to SEQ_IDLE and starts nothing. This includes a wrong sixth erase byte.
- R7: A read is registered: `rd_data` changes on the clock edge that samples `rd_en`. After the edge that samples a starting write, the block is busy for exactly PROG_CYC, SECT_ERASE_CYC or CHIP_ERASE_CYC edges. Reads sampled on those edges return {DQ7, DQ6, 000000b}.
- R8: The status DQ7 is the complement of bit 7 of the programmed data. For an erase it is 0.
- R9: The status DQ6 is 0 on the first read after an operation starts and inverts on every further status read.
- R10: Writes sampled while busy are ignored and do not advance the decoder.
- R11: The unlock writes with 90H as third byte enter ID mode. In ID mode a non-busy read returns BFH when `addr[0]`=0 and B7H when `addr[0]`=1.
- R12: A write of F0H at any address, in any decoder state other than SEQ_PGM_DATA, leaves ID mode and returns to SEQ_IDLE. This also covers the three-byte form AAH@5555H, 55H@2AAAH, F0H@5555H. An F0H in the program-data slot is ordinary program data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Bus address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data or status |

## Verification
The bench goes after near-miss unlock sequences: one wrong address bit in a step, and a wrong final erase byte. A decoder that matched on data alone would then program or erase bytes that should stay intact. It also checks F0H used as program data. A decoder that tested for the exit code first would drop the program and leave the byte unchanged. Status reads are held back to back across the whole busy window, so an off-by-one busy counter or a toggle that fails to start at 0 shows up on a single read. The bench issues a full program sequence while the block is busy. A design that let that sequence through would change a second byte. It also runs a sector erase next to live data in the neighbouring sector, which catches a sector field decoded from the wrong bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_UNL1,
        SEQ_UNL2,
        SEQ_PGM_DATA,
        SEQ_ERS3,
        SEQ_ERS4,
        SEQ_ERS5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_e;

    localparam int          UNL_W     = 15;
    localparam logic [14:0] ADR_FIRST = 15'h5555;
    localparam logic [14:0] ADR_SECOND = 15'h2AAA;

    localparam logic [7:0] CODE_UNL_A  = 8'hAA;
    localparam logic [7:0] CODE_UNL_B  = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_ID_IN  = 8'h90;
    localparam logic [7:0] CODE_ID_OUT = 8'hF0;

    localparam logic [7:0] ID_MAKER = 8'hBF;
    localparam logic [7:0] ID_PART  = 8'hB7;

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output op_e               op_start,
    output logic              id_mode,
    output seq_state_e        state
);

    seq_state_e state_nxt;
    logic       id_nxt;
    logic       at_first;
    logic       at_second;

    assign at_first  = (addr[UNL_W-1:0] == ADR_FIRST);
    assign at_second = (addr[UNL_W-1:0] == ADR_SECOND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            state   <= state_nxt;
            id_mode <= id_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        id_nxt    = id_mode;
        op_start  = OP_NONE;
        if (wr_en && !busy) begin
            if (state != SEQ_PGM_DATA && data == CODE_ID_OUT) begin
                state_nxt = SEQ_IDLE;
                id_nxt    = 1'b0;
            end else begin
                state_nxt = SEQ_IDLE;
                unique case (state)
                    SEQ_IDLE: begin
                        if (data == CODE_UNL_A && at_first) state_nxt = SEQ_UNL1;
                    end
                    SEQ_UNL1: begin
                        if (data == CODE_UNL_B && at_second) state_nxt = SEQ_UNL2;
                    end
                    SEQ_UNL2: begin
                        if (at_first) begin
                            if (data == CODE_PROG)  state_nxt = SEQ_PGM_DATA;
                            if (data == CODE_ERASE) state_nxt = SEQ_ERS3;
                            if (data == CODE_ID_IN) id_nxt    = 1'b1;
                        end
                    end
                    SEQ_PGM_DATA: begin
                        op_start = OP_PROG;
                    end
                    SEQ_ERS3: begin
                        if (data == CODE_UNL_A && at_first) state_nxt = SEQ_ERS4;
                    end
                    SEQ_ERS4: begin
                        if (data == CODE_UNL_B && at_second) state_nxt = SEQ_ERS5;
                    end
                    SEQ_ERS5: begin
                        if (data == CODE_CHIP && at_first) op_start = OP_CHIP;
                        else if (data == CODE_SECT)        op_start = OP_SECT;
                    end
                    default: state_nxt = SEQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC       = 5,
    parameter int SECT_ERASE_CYC = 12,
    parameter int CHIP_ERASE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  op_e  op_start,
    output logic busy
);

    localparam int MAX_A  = (PROG_CYC > SECT_ERASE_CYC) ? PROG_CYC : SECT_ERASE_CYC;
    localparam int MAX_C  = (MAX_A > CHIP_ERASE_CYC) ? MAX_A : CHIP_ERASE_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op_start)
                OP_PROG: cnt_q <= CNT_W'(PROG_CYC);
                OP_SECT: cnt_q <= CNT_W'(SECT_ERASE_CYC);
                OP_CHIP: cnt_q <= CNT_W'(CHIP_ERASE_CYC);
                OP_NONE: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
    import flash_cmd_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int SOFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op_start,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH*8-1:0] flat;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
        logic [7:0] word_q;
        logic       sect_hit;

        assign sect_hit = (MY_IDX[IDX_W-1:SOFF_W] == wr_idx[IDX_W-1:SOFF_W]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= 8'hFF;
            end else if (op_start == OP_CHIP || (op_start == OP_SECT && sect_hit)) begin
                word_q <= 8'hFF;
            end else if (op_start == OP_PROG && wr_idx == MY_IDX) begin
                word_q <= word_q & wr_byte;
            end
        end

        assign flat[gi*8 +: 8] = word_q;
    end

    assign rd_byte = flat[rd_idx*8 +: 8];

endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W         = 15,
    parameter int IDX_W          = 6,
    parameter int SOFF_W         = 4,
    parameter int PROG_CYC       = 5,
    parameter int SECT_ERASE_CYC = 12,
    parameter int CHIP_ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);

    localparam int MAX_A        = (PROG_CYC > SECT_ERASE_CYC) ? PROG_CYC : SECT_ERASE_CYC;
    localparam int MAX_BUSY_CYC = (MAX_A > CHIP_ERASE_CYC) ? MAX_A : CHIP_ERASE_CYC;

    op_e        op_start;
    logic       busy;
    logic       id_mode;
    seq_state_e seq_state;
    logic [7:0] arr_byte;
    logic       st7_q;
    logic       tog_q;

    flash_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .addr     (addr),
        .data     (wr_data),
        .op_start (op_start),
        .id_mode  (id_mode),
        .state    (seq_state)
    );

    flash_busy_timer #(
        .PROG_CYC       (PROG_CYC),
        .SECT_ERASE_CYC (SECT_ERASE_CYC),
        .CHIP_ERASE_CYC (CHIP_ERASE_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .busy     (busy)
    );

    flash_byte_array #(.IDX_W(IDX_W), .SOFF_W(SOFF_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .wr_idx   (addr[IDX_W-1:0]),
        .wr_byte  (wr_data),
        .rd_idx   (addr[IDX_W-1:0]),
        .rd_byte  (arr_byte)
    );

    // read path and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
            st7_q   <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            if (op_start != OP_NONE) begin
                tog_q <= 1'b0;
                st7_q <= (op_start == OP_PROG) ? ~wr_data[7] : 1'b0;
            end
            if (rd_en && !wr_en) begin
                if (busy) begin
                    rd_data <= {st7_q, tog_q, 6'b0};
                    tog_q   <= ~tog_q;
                end else if (id_mode) begin
                    rd_data <= addr[0] ? ID_PART : ID_MAKER;
                end else begin
                    rd_data <= arr_byte;
                end
            end
        end
    end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int MAX_BUSY = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       id_mode,
    input seq_state_e seq_state
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R10
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_state == SEQ_IDLE);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < MAX_BUSY);

    // R7
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R7
    stat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && busy) |=> rd_data[5:0] == 6'b0);

    // R9
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=> rd_data[6] != $past(rd_data[6]));

    // R11
    id_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(id_mode) |-> $past(wr_en));

endmodule

bind flash_cmd_core flash_cmd_chk #(.MAX_BUSY(MAX_BUSY_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .busy      (busy),
    .id_mode   (id_mode),
    .seq_state (seq_state)
);

// File: tb/tb_flash_cmd_core.sv
`timescale 1ns/1ps
module tb_flash_cmd_core;

    localparam int AW   = 15;
    localparam int PROG = 5;
    localparam int SECT = 12;
    localparam int CHIP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    flash_cmd_core #(
        .ADDR_W(AW), .IDX_W(6), .SOFF_W(4),
        .PROG_CYC(PROG), .SECT_ERASE_CYC(SECT), .CHIP_ERASE_CYC(CHIP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    // behavioural reference model
    logic [7:0] m_mem [64];
    bit         m_id;
    int         m_step;
    int         m_busy;
    bit         m_st7, m_tog;
    logic [7:0] m_rd;

    always @(posedge clk) begin
        int b0;
        bit started;
        b0 = m_busy;
        started = 0;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
            m_id = 0; m_step = 0; m_busy = 0; m_st7 = 0; m_tog = 0; m_rd = 8'h00;
        end else begin
            if (wr_en && b0 == 0) begin
                if (m_step == 3) begin
                    m_mem[addr[5:0]] = m_mem[addr[5:0]] & wr_data;
                    m_st7 = ~wr_data[7]; m_tog = 0; m_busy = PROG; started = 1; m_step = 0;
                end else if (wr_data == 8'hF0) begin
                    m_id = 0; m_step = 0;
                end else begin
                    int nxt;
                    nxt = 0;
                    case (m_step)
                        0: if (wr_data == 8'hAA && addr == 15'h5555) nxt = 1;
                        1: if (wr_data == 8'h55 && addr == 15'h2AAA) nxt = 2;
                        2: if (addr == 15'h5555) begin
                               if (wr_data == 8'hA0) nxt = 3;
                               if (wr_data == 8'h80) nxt = 4;
                               if (wr_data == 8'h90) m_id = 1;
                           end
                        4: if (wr_data == 8'hAA && addr == 15'h5555) nxt = 5;
                        5: if (wr_data == 8'h55 && addr == 15'h2AAA) nxt = 6;
                        6: begin
                               if (wr_data == 8'h10 && addr == 15'h5555) begin
                                   for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
                                   m_busy = CHIP; started = 1; m_st7 = 0; m_tog = 0;
                               end else if (wr_data == 8'h30) begin
                                   for (int i = 0; i < 64; i++)
                                       if ((i >> 4) == (int'(addr[5:0]) >> 4)) m_mem[i] = 8'hFF;
                                   m_busy = SECT; started = 1; m_st7 = 0; m_tog = 0;
                               end
                           end
                        default: nxt = 0;
                    endcase
                    m_step = nxt;
                end
            end
            if (rd_en && !wr_en) begin
                if (b0 > 0) begin
                    m_rd = {m_st7, m_tog, 6'b0};
                    m_tog = !m_tog;
                end else if (m_id) begin
                    m_rd = addr[0] ? 8'hB7 : 8'hBF;
                end else begin
                    m_rd = m_mem[addr[5:0]];
                end
            end
            if (!started && b0 > 0) m_busy = b0 - 1;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // compare with model every clock
    always @(negedge clk) begin
        if (rst_n) chk({cur_req, " model"}, rd_data, m_rd);
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic unlock3(input logic [7:0] c);
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
        wr(15'h5555, c);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        unlock3(8'hA0);
        wr(a, d);
    endtask

    task automatic erase6(input logic [AW-1:0] a, input logic [7:0] d);
        unlock3(8'h80);
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
        wr(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        cur_req = "R1";
        chk("R1 rd_data", rd_data, 8'h00);
        rd_check("R1", 15'h0000, 8'hFF);
        rd_check("R1", 15'h003F, 8'hFF);

        // R2 R7 R8 R9 program with back-to-back status reads
        cur_req = "R7";
        prog(15'h0005, 8'h3C);
        rd_en = 1'b1; addr = 15'h0005;
        for (int j = 1; j <= PROG + 1; j++) begin
            @(negedge clk);
            if (j <= PROG) chk("R7 R8 R9 status", rd_data, {1'b1, (j % 2 == 0), 6'b0});
            else           chk("R2 R7 done", rd_data, 8'h3C);
        end
        rd_en = 1'b0;

        // R3 R12 F0 as program data is ANDed
        cur_req = "R3";
        prog(15'h0005, 8'hF0);
        idle(PROG + 1);
        rd_check("R3 R12", 15'h0005, 8'h30);

        // R8 status with bit7 set in data
        cur_req = "R8";
        prog(15'h0006, 8'hA5);
        rd_check("R8", 15'h0006, 8'h00);
        idle(PROG);
        rd_check("R2", 15'h0006, 8'hA5);

        // R6 wrong address in unlock
        cur_req = "R6";
        wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'hA0); wr(15'h0007, 8'h00);
        idle(PROG + 1);
        rd_check("R6", 15'h0007, 8'hFF);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5554, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h10);
        idle(CHIP + 1);
        rd_check("R6", 15'h0005, 8'h30);

        // R10 writes ignored while busy
        cur_req = "R10";
        prog(15'h0008, 8'h11);
        prog(15'h0009, 8'h22);
        idle(PROG + 2);
        rd_check("R10", 15'h0008, 8'h11);
        rd_check("R10", 15'h0009, 8'hFF);

        // R11 ID mode reads
        cur_req = "R11";
        unlock3(8'h90);
        rd_check("R11", 15'h0000, 8'hBF);
        rd_check("R11", 15'h0001, 8'hB7);
        rd_check("R11", 15'h0003, 8'hB7);
        rd_check("R11", 15'h0002, 8'hBF);
        // R12 exit by F0 at any address
        cur_req = "R12";
        wr(15'h1234, 8'hF0);
        rd_check("R12", 15'h0005, 8'h30);
        unlock3(8'h90);
        wr(15'h5555, 8'hAA);
        wr(15'h0777, 8'hF0);
        rd_check("R12", 15'h0001, 8'hFF);
        unlock3(8'h90);
        unlock3(8'hF0);
        rd_check("R12", 15'h0000, 8'hFF);

        // R5 sector erase
        cur_req = "R5";
        prog(15'h0012, 8'h5A); idle(PROG + 1);
        prog(15'h0021, 8'h66); idle(PROG + 1);
        erase6(15'h001C, 8'h30);
        rd_check("R5 R8", 15'h0012, 8'h00);
        idle(SECT);
        rd_check("R5", 15'h0012, 8'hFF);
        rd_check("R5", 15'h0005, 8'h30);
        rd_check("R5", 15'h0021, 8'h66);

        // R6 wrong sixth byte
        cur_req = "R6";
        erase6(15'h0020, 8'h20);
        idle(SECT + 1);
        rd_check("R6", 15'h0021, 8'h66);

        // R4 chip erase
        cur_req = "R4";
        erase6(15'h5555, 8'h10);
        rd_check("R4 R9", 15'h0005, 8'h00);
        rd_check("R4 R9", 15'h0005, 8'h40);
        idle(CHIP);
        rd_check("R4", 15'h0005, 8'hFF);
        rd_check("R4", 15'h0021, 8'hFF);
        rd_check("R4", 15'h0008, 8'hFF);

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule